// File: doc/BRIEF.md
# Memory Protection Region Access Checker

This block judges every processor bus access against eight programmable memory regions. For each access it decides whether the access may proceed or must raise a memory-management fault. It also reports which region, if any, made that decision. Software sets the block up through a small register window with four word slots:

- a control word holding the global enable, the privileged fall-back enable and the high-priority-handler enable;
- a region selector;
- a base-address slot for the selected region;
- an attribute slot for the selected region.

Each access presents an address, a privilege flag, an access kind and the current execution priority. The decision logic is combinational. Its result is registered, so the verdict appears one clock after the access is presented.

Before any region is checked, the block applies these rules:

- An instruction fetch from the system control space (`0xE000E000`–`0xE000EFFF`) is always refused.
- The block can be disabled, in which case accesses are not checked.
- Handlers running at priority -1 or -2 can bypass checking.
- Accesses to the system control space and to the vector table (addresses below `0x400`) are always let through.

When several enabled regions cover one address, the highest-numbered region wins.

Top module: `region_guard`

## Requirements
- R1: After synchronous reset, every register reads as zero: control, selector, and base and attribute of every region. The block is then disabled, and `res_valid`, `res_fault`, `res_hit` and `res_region` are 0.
- R2: Register slot 1 (selector) stores bits [2:0] of a write and ignores bits [31:3]. Slot 2 (base) and slot 3 (attribute) read and write the region named by the selector. Base reads as {base[31:5], bit4=0, bit3=0, selector[2:0]}. Attribute reads as {xn at bit 12, ap at [10:8], size at [5:1], enable at bit 0}, with all other bits 0. Control (slot 0) holds enable at bit 0, privileged fall-back at bit 1 and high-priority enable at bit 2.
- R3: A base write with bit 4 (VALID) set does two things: it loads bits [2:0] into the selector, and it writes the base of that region. A base write with bit 4 clear writes the currently selected region and leaves the selector unchanged.
- R4: With control bit 0 clear, every access except a fetch from the system control space is allowed, with `res_hit`=0.
- R5: An instruction fetch (`acc_kind`=2) to `0xE000E000`–`0xE000EFFF` faults, with `res_hit`=0, whatever the control settings.
- R6: When enabled, reads and writes to the system control space, and any access below `0x400`, are allowed with `res_hit`=0.
- R7: When enabled, an unprivileged access that matches no enabled region faults, with `res_hit`=0.
- R8: When enabled, a privileged access that matches no enabled region faults when control bit 1 is clear. It is allowed when control bit 1 is set.
- R9: When `acc_prio` equals -1 or -2 (two's complement) and control bit 2 is clear, the access is allowed without checking and `res_hit`=0. With control bit 2 set, the access is checked normally.
- R10: When several enabled regions cover the address, the highest-numbered one decides. `res_hit`=1 and `res_region` gives its index.
- R11: Access-permission codes grant access as follows; any other code denies everything. A fetch counts as a read.

  | Code | Privileged access | Unprivileged access |
  |------|-------------------|---------------------|
  | 1 | read and write | none |
  | 2 | read and write | read only |
  | 3 | read and write | read and write |
  | 5 | read only | none |
  | 6, 7 | read only | read only |

- R12: A fetch that hits a region whose xn bit is set faults.
- R13: The size code s covers 2^(s+1) bytes aligned to that size. Codes below 4 act as 4, which gives 32 bytes.
- R14: `res_valid` equals `acc_valid` one clock earlier. When `res_valid` is 0, `res_fault`, `res_hit` and `res_region` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Slot: 0 control, 1 selector, 2 base, 3 attribute |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of slot `reg_addr` |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | 1 = privileged |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_prio | input | 9 | Execution priority, two's complement |
| res_valid | output | 1 | Verdict valid (one clock after access) |
| res_fault | output | 1 | Memory-management fault |
| res_hit | output | 1 | A region decided the verdict |
| res_region | output | 3 | Index of the deciding region |

## Verification
A register write and an access can land in the same clock. The bench provokes this by disabling a region through the attribute slot while an access to that region is presented. The verdict must still follow the old setting. The next access must see the lower region take over. The behavioural model in the bench applies a write only after the clock edge. The verdict is compared against that model on every cycle, including idle cycles.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int AW       = 32;
    localparam int BASE_LSB = 5;
    localparam int VALID_BIT = 4;
    localparam int MIN_SIZE = 4;

    localparam logic [AW-1:0] SCS_LO   = 32'hE000_E000;
    localparam logic [AW-1:0] SCS_HI   = 32'hE000_EFFF;
    localparam logic [AW-1:0] VTAB_END = 32'h0000_0400;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_SEL  = 2'd1,
        RA_BASE = 2'd2,
        RA_ATTR = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic hpen;
        logic privdef;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic       xn;
        logic [2:0] ap;
        logic [4:0] size;
        logic       en;
    } attr_t;

    typedef struct packed {
        logic [AW-1:BASE_LSB] base;
        attr_t                attr;
    } region_t;

    // Permission table for one access; fetch is passed in as a read.
    function automatic logic ap_permits(logic [2:0] ap, logic priv, logic wr);
        logic ok;
        case (ap)
            3'd1:    ok = priv;
            3'd2:    ok = priv | ~wr;
            3'd3:    ok = 1'b1;
            3'd5:    ok = priv & ~wr;
            3'd6,
            3'd7:    ok = ~wr;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Mask of the address bits that select a region of size code sz.
    function automatic logic [AW-1:0] size_mask(logic [4:0] sz);
        logic [4:0]  eff;
        logic [AW:0] span;
        logic [AW:0] low;
        eff  = (sz < 5'(MIN_SIZE)) ? 5'(MIN_SIZE) : sz;
        span = (AW+1)'(1) << (int'(eff) + 1);
        low  = span - (AW+1)'(1);
        return ~low[AW-1:0];
    endfunction

endpackage

// File: rtl/rg_regfile.sv
module rg_regfile
    import rg_pkg::*;
#(
    parameter  int NREG   = 8,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [AW-1:0]     wdata,
    output logic [AW-1:0]     rdata,
    output ctrl_t             ctrl,
    output logic [RIDX_W-1:0] sel,
    output region_t           regs [NREG]
);

    logic              is_base;
    logic              is_attr;
    logic              bar_valid;
    logic [RIDX_W-1:0] bar_idx;
    logic [RIDX_W-1:0] tgt;
    attr_t             wattr;
    region_t           cur;

    assign is_base   = (reg_addr_e'(addr) == RA_BASE);
    assign is_attr   = (reg_addr_e'(addr) == RA_ATTR);
    assign bar_valid = wdata[VALID_BIT];
    assign bar_idx   = wdata[RIDX_W-1:0];
    assign tgt       = (is_base && bar_valid) ? bar_idx : sel;
    assign wattr     = '{xn: wdata[12], ap: wdata[10:8], size: wdata[5:1], en: wdata[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            sel  <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                RA_CTRL: ctrl <= ctrl_t'(wdata[2:0]);
                RA_SEL:  sel  <= wdata[RIDX_W-1:0];
                RA_BASE: if (bar_valid) sel <= bar_idx;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && tgt == RIDX_W'(i)) begin
                if (is_base)      regs[i].base <= wdata[AW-1:BASE_LSB];
                else if (is_attr) regs[i].attr <= wattr;
            end
        end
    end

    assign cur = regs[sel];

    always_comb begin
        case (reg_addr_e'(addr))
            RA_CTRL: rdata = {{(AW-3){1'b0}}, ctrl};
            RA_SEL:  rdata = {{(AW-RIDX_W){1'b0}}, sel};
            RA_BASE: rdata = {cur.base, {(BASE_LSB-RIDX_W){1'b0}}, sel};
            default: rdata = {{(AW-13){1'b0}}, cur.attr.xn, 1'b0, cur.attr.ap,
                              2'b00, cur.attr.size, cur.attr.en};
        endcase
    end

endmodule

// File: rtl/rg_match.sv
module rg_match
    import rg_pkg::*;
#(
    parameter  int NREG   = 8,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic [AW-1:0]     addr,
    input  region_t           regs [NREG],
    output logic              any,
    output logic [RIDX_W-1:0] idx,
    output logic              xn,
    output logic [2:0]        ap
);

    logic [NREG-1:0] hit;

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign hit[i] = regs[i].attr.en &&
            (((addr ^ {regs[i].base, {BASE_LSB{1'b0}}}) & size_mask(regs[i].attr.size)) == '0);
    end

    // Later (higher) indices overwrite earlier ones: highest region wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                any = 1'b1;
                idx = RIDX_W'(i);
            end
        end
        xn = regs[idx].attr.xn;
        ap = regs[idx].attr.ap;
    end

endmodule

// File: rtl/rg_decide.sv
module rg_decide
    import rg_pkg::*;
#(
    parameter  int NREG   = 8,
    parameter  int PRIO_W = 9,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  ctrl_t             ctrl,
    input  logic [AW-1:0]     addr,
    input  logic              priv,
    input  logic [1:0]        kind,
    input  logic [PRIO_W-1:0] prio,
    input  logic              any,
    input  logic [RIDX_W-1:0] idx,
    input  logic              xn,
    input  logic [2:0]        ap,
    output logic              fault,
    output logic              rhit,
    output logic [RIDX_W-1:0] ridx
);

    logic in_scs;
    logic in_vt;
    logic is_fetch;
    logic is_wr;
    logic hp_pri;

    assign in_scs   = (addr >= SCS_LO) && (addr <= SCS_HI);
    assign in_vt    = (addr < VTAB_END);
    assign is_fetch = (acc_kind_e'(kind) == ACC_FETCH);
    assign is_wr    = (acc_kind_e'(kind) == ACC_WRITE);
    assign hp_pri   = (prio == {PRIO_W{1'b1}}) || (prio == {{(PRIO_W-1){1'b1}}, 1'b0});

    always_comb begin
        fault = 1'b0;
        rhit  = 1'b0;
        ridx  = '0;
        if (in_scs && is_fetch) begin
            fault = 1'b1;
        end else if (!ctrl.en) begin
            fault = 1'b0;
        end else if (hp_pri && !ctrl.hpen) begin
            fault = 1'b0;
        end else if (in_scs || in_vt) begin
            fault = 1'b0;
        end else if (any) begin
            rhit  = 1'b1;
            ridx  = idx;
            fault = (is_fetch && xn) || !ap_permits(ap, priv, is_wr);
        end else begin
            fault = !(priv && ctrl.privdef);
        end
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rg_pkg::*;
#(
    parameter  int NREG   = 8,
    parameter  int PRIO_W = 9,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_priv,
    input  logic [1:0]        acc_kind,
    input  logic [PRIO_W-1:0] acc_prio,
    output logic              res_valid,
    output logic              res_fault,
    output logic              res_hit,
    output logic [RIDX_W-1:0] res_region
);

    ctrl_t             ctrl_q;
    logic [RIDX_W-1:0] sel_q;
    region_t           regs [NREG];
    logic              m_any;
    logic [RIDX_W-1:0] m_idx;
    logic              m_xn;
    logic [2:0]        m_ap;
    logic              d_fault;
    logic              d_hit;
    logic [RIDX_W-1:0] d_idx;

    rg_regfile #(.NREG(NREG)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl_q),
        .sel   (sel_q),
        .regs  (regs)
    );

    rg_match #(.NREG(NREG)) u_match (
        .addr (acc_addr),
        .regs (regs),
        .any  (m_any),
        .idx  (m_idx),
        .xn   (m_xn),
        .ap   (m_ap)
    );

    rg_decide #(.NREG(NREG), .PRIO_W(PRIO_W)) u_decide (
        .ctrl  (ctrl_q),
        .addr  (acc_addr),
        .priv  (acc_priv),
        .kind  (acc_kind),
        .prio  (acc_prio),
        .any   (m_any),
        .idx   (m_idx),
        .xn    (m_xn),
        .ap    (m_ap),
        .fault (d_fault),
        .rhit  (d_hit),
        .ridx  (d_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_fault  <= 1'b0;
            res_hit    <= 1'b0;
            res_region <= '0;
        end else begin
            res_valid  <= acc_valid;
            res_fault  <= acc_valid & d_fault;
            res_hit    <= acc_valid & d_hit;
            res_region <= acc_valid ? d_idx : '0;
        end
    end

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk
    import rg_pkg::*;
#(
    parameter  int NREG   = 8,
    parameter  int PRIO_W = 9,
    localparam int RIDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst,
    input logic              base_wr,
    input logic              base_vld,
    input logic [RIDX_W-1:0] base_idx,
    input logic              acc_valid,
    input logic [31:0]       acc_addr,
    input logic              acc_priv,
    input logic [1:0]        acc_kind,
    input logic [PRIO_W-1:0] acc_prio,
    input logic              en,
    input logic              hpen,
    input logic [RIDX_W-1:0] sel,
    input logic              m_any,
    input logic              res_valid,
    input logic              res_fault,
    input logic              res_hit
);

    logic scs, vt, fetch, hp, sysx;
    assign scs   = (acc_addr >= SCS_LO) && (acc_addr <= SCS_HI);
    assign vt    = (acc_addr < VTAB_END);
    assign fetch = (acc_kind == 2'd2);
    assign hp    = (acc_prio == {PRIO_W{1'b1}}) || (acc_prio == {{(PRIO_W-1){1'b1}}, 1'b0});
    assign sysx  = scs && fetch;

    // R14
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);
    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!res_valid && !res_fault && !res_hit));
    // R5
    scs_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && sysx) |=> (res_fault && !res_hit));
    // R4
    off_allow_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !en && !sysx) |=> (!res_fault && !res_hit));
    // R6
    sys_allow_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && en && !sysx && (scs || vt)) |=> !res_fault);
    // R9
    hp_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && en && hp && !hpen && !sysx) |=> (!res_fault && !res_hit));
    // R7
    user_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && en && !acc_priv && !m_any && !scs && !vt && !(hp && !hpen))
        |=> (res_fault && !res_hit));
    // R3
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (base_wr && base_vld) |=> (sel == $past(base_idx)));
    // R3
    sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (base_wr && !base_vld) |=> $stable(sel));

endmodule

bind region_guard region_guard_chk #(.NREG(NREG), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .base_wr   (reg_we && reg_addr == 2'd2),
    .base_vld  (reg_wdata[4]),
    .base_idx  (reg_wdata[RIDX_W-1:0]),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_priv  (acc_priv),
    .acc_kind  (acc_kind),
    .acc_prio  (acc_prio),
    .en        (ctrl_q.en),
    .hpen      (ctrl_q.hpen),
    .sel       (sel_q),
    .m_any     (m_any),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_hit   (res_hit)
);

// File: tb/region_guard_tb.sv
module region_guard_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_priv = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [8:0]  acc_prio = '0;
    logic        res_valid, res_fault, res_hit;
    logic [2:0]  res_region;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    region_guard u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_kind(acc_kind),
        .acc_prio(acc_prio), .res_valid(res_valid), .res_fault(res_fault),
        .res_hit(res_hit), .res_region(res_region)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    bit [31:0] mb [8];
    bit        me [8];
    int        msz [8];
    int        map [8];
    bit        mx [8];
    int        msel;
    bit        c_en, c_pd, c_hp;

    function automatic [31:0] attr_w(bit en, int sz, int ap, bit xn);
        return {19'b0, xn, 1'b0, 3'(ap), 2'b0, 5'(sz), en};
    endfunction

    function automatic void model_wr(int a, bit [31:0] d);
        case (a)
            0: begin c_en = d[0]; c_pd = d[1]; c_hp = d[2]; end
            1: msel = int'(d[2:0]);
            2: begin
                if (d[4]) msel = int'(d[2:0]);
                mb[msel] = {d[31:5], 5'b0};
            end
            default: begin
                me[msel] = d[0]; msz[msel] = int'(d[5:1]);
                map[msel] = int'(d[10:8]); mx[msel] = d[12];
            end
        endcase
    endfunction

    function automatic [31:0] model_rd(int a);
        case (a)
            0: return {29'b0, c_hp, c_pd, c_en};
            1: return 32'(msel);
            2: return {mb[msel][31:5], 2'b0, 3'(msel)};
            default: return attr_w(me[msel], msz[msel], map[msel], mx[msel]);
        endcase
    endfunction

    function automatic void model_eval(bit [31:0] a, bit pr, int k, int pri,
                                       output bit f, output bit h, output int idx);
        bit scs, vt, wr, ok;
        int found;
        longint span;
        scs = (a >= 32'hE000_E000) && (a <= 32'hE000_EFFF);
        vt  = (a < 32'h400);
        wr  = (k == 1);
        f = 0; h = 0; idx = 0;
        if (scs && k == 2) f = 1;
        else if (!c_en) f = 0;
        else if ((pri == -1 || pri == -2) && !c_hp) f = 0;
        else if (scs || vt) f = 0;
        else begin
            found = -1;
            for (int r = 7; r >= 0; r--) begin
                if (found < 0 && me[r]) begin
                    span = 64'd1 << ((msz[r] < 4 ? 4 : msz[r]) + 1);
                    if (longint'(a) / span == longint'(mb[r]) / span) found = r;
                end
            end
            if (found >= 0) begin
                h = 1; idx = found;
                case (map[found])
                    1: ok = pr;
                    2: ok = pr || !wr;
                    3: ok = 1;
                    5: ok = pr && !wr;
                    6, 7: ok = !wr;
                    default: ok = 0;
                endcase
                f = !ok || (k == 2 && mx[found]);
            end else begin
                f = !(pr && c_pd);
            end
        end
    endfunction

    // One clock: predict, clock, apply write to model, compare outputs.
    task automatic step(string tag);
        bit ev, ef, eh;
        int ei;
        ev = acc_valid; ef = 0; eh = 0; ei = 0;
        if (acc_valid) model_eval(acc_addr, acc_priv, int'(acc_kind), int'($signed(acc_prio)), ef, eh, ei);
        @(posedge clk);
        if (reg_we) model_wr(int'(reg_addr), reg_wdata);
        #1;
        checks++;
        if (res_valid !== ev || res_fault !== ef || res_hit !== eh || res_region !== 3'(ei)) begin
            fails++;
            $display("FAIL %s: got v=%0b f=%0b h=%0b r=%0d expected v=%0b f=%0b h=%0b r=%0d",
                     tag, res_valid, res_fault, res_hit, res_region, ev, ef, eh, ei);
        end
        @(negedge clk);
        reg_we = 0;
        acc_valid = 0;
    endtask

    task automatic wr(int a, bit [31:0] d, string tag);
        reg_we = 1; reg_addr = 2'(a); reg_wdata = d;
        step(tag);
    endtask

    task automatic acc(bit [31:0] a, bit pr, int k, int pri, string tag);
        acc_valid = 1; acc_addr = a; acc_priv = pr; acc_kind = 2'(k); acc_prio = 9'(pri);
        step(tag);
    endtask

    task automatic rd_chk(int a, string tag);
        bit [31:0] e;
        reg_addr = 2'(a);
        #1;
        e = model_rd(a);
        checks++;
        if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s: slot %0d got %h expected %h", tag, a, reg_rdata, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++) begin
            mb[r] = 0; me[r] = 0; msz[r] = 0; map[r] = 0; mx[r] = 0;
        end
        msel = 0; c_en = 0; c_pd = 0; c_hp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset contents and quiet outputs
        for (int a = 0; a < 4; a++) rd_chk(a, "R1");
        step("R1");

        // R2, R3: programming through the shared windows
        wr(1, 32'h1, "R2");
        wr(2, 32'h2000_0000, "R3");
        wr(3, attr_w(1, 11, 3, 0), "R2");
        rd_chk(2, "R2");
        rd_chk(3, "R2");
        wr(2, 32'h2000_0800 | 32'h10 | 32'h5, "R3");
        rd_chk(1, "R3");
        wr(3, attr_w(1, 7, 6, 1), "R3");
        wr(2, 32'h2000_0803, "R3");
        rd_chk(1, "R3");
        rd_chk(2, "R3");
        wr(2, 32'h3000_0000 | 32'h10 | 32'h2, "R13");
        wr(3, attr_w(1, 2, 1, 0), "R13");
        wr(1, 32'h0000_FF05, "R2");
        rd_chk(1, "R2");
        rd_chk(3, "R2");

        // R4, R5: unit disabled
        acc(32'h5000_0000, 0, 1, 0, "R4");
        acc(32'h2000_0810, 0, 1, 0, "R4");
        acc(32'hE000_ED00, 1, 2, 0, "R5");

        wr(0, 32'h1, "R1");
        rd_chk(0, "R2");
        acc(32'h2000_0100, 0, 1, 0, "R11");
        acc(32'h2000_0810, 0, 1, 0, "R10");
        acc(32'h2000_0810, 0, 0, 0, "R10");
        acc(32'h2000_0810, 1, 2, 0, "R12");
        acc(32'h2000_0100, 0, 2, 0, "R12");
        acc(32'h5000_0000, 0, 0, 0, "R7");
        acc(32'h5000_0000, 1, 0, 0, "R8");
        acc(32'hE000_ED00, 0, 1, 0, "R6");
        acc(32'h0000_0100, 0, 1, 0, "R6");
        acc(32'hE000_E010, 1, 2, 0, "R5");
        acc(32'h3000_001F, 1, 1, 0, "R13");
        acc(32'h3000_001F, 0, 0, 0, "R11");
        acc(32'h3000_0020, 0, 0, 0, "R13");
        acc(32'h5000_0000, 0, 0, -1, "R9");
        acc(32'h5000_0000, 0, 0, -2, "R9");
        acc(32'h5000_0000, 0, 0, -3, "R9");
        wr(0, 32'h3, "R8");
        acc(32'h5000_0000, 1, 1, 0, "R8");
        acc(32'h5000_0000, 0, 1, 0, "R7");
        wr(0, 32'h5, "R9");
        acc(32'h5000_0000, 0, 0, -1, "R9");
        acc(32'hE000_E000, 0, 2, -1, "R5");

        // Register write and access in the same cycle (region 5 off)
        wr(1, 32'h5, "R2");
        reg_we = 1; reg_addr = 2'd3; reg_wdata = attr_w(0, 7, 6, 1);
        acc_valid = 1; acc_addr = 32'h2000_0810; acc_priv = 0; acc_kind = 2'd1; acc_prio = '0;
        step("R10");
        acc(32'h2000_0810, 0, 1, 0, "R10");
        step("R14");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule